// File: doc/BRIEF.md
# Gate Driver Enable and Fault Sequencer

This block sits between a gate-driver controller's enable input, its analog protection comparators and its three-phase gate logic. It decides when the power stage may switch, and it reports trouble on two active-low lines. A rising enable starts a long start-up wait before the ready flag and the gate release. A short low pulse on enable acts as a fast fault-clear, which skips that wait. A longer low pulse is treated as a full shutdown.

Shutdown-class conditions kill the gates and latch the fault line until the next clear. These conditions are supply undervoltage, gate-supply undervoltage, gate-supply overvoltage and junction over-temperature. Per-phase drain-source overcurrent flags are only reported, as warning pulses with a guaranteed minimum width. Over-temperature warning and shutdown each use a set/clear hysteresis pair on a registered, signed Celsius code. All time constants are given in clock cycles and are set through parameters; the defaults assume a 50 MHz clock.

Top module: `drv_fault_seq`

## Requirements
- R1: After reset, ready_o is 0, gate_kill_o is 1, fault_n_o is 1 and warn_n_o is 1.
- R2: ready_o rises exactly STARTUP_CYC clock cycles after the first rising edge at which en_i is sampled high from the off state. gate_kill_o falls in the same cycle.
- R3: If en_i is sampled low during the start-up wait, the block returns to off. The next enable again waits the full STARTUP_CYC.
- R4: An en_i low pulse of 1 to QUICK_CYC sampled cycles is a quick reset. On the first edge at which en_i is high again, ready_o returns to 1 and the fault latch is cleared.
- R5: An en_i low pulse of QUICK_CYC+1 or more sampled cycles is a full shutdown. The next enable waits the full STARTUP_CYC before ready_o rises.
- R6: While en_i is low, ready_o is 0 and gate_kill_o is 1 from the next clock edge on.
- R7: Each overcurrent flag oc_i[p] (bit p = phase p) sampled high drives warn_n_o low from the next edge. A one-cycle flag gives exactly OC_STRETCH_CYC low cycles. A flag held for H cycles gives H-1+OC_STRETCH_CYC low cycles. Overcurrent never affects fault_n_o or gate_kill_o.
- R8: The temperature warning drives warn_n_o low once the registered temperature is at least OTW_SET (130). It stays low until the temperature is at most OTW_CLR (115). Latency from temp_i is two clock edges.
- R9: Over-temperature shutdown sets at a registered temperature of at least OTSD_SET (150) and clears at most OTSD_CLR (130). While it is set and the block runs, the fault latch sets within three edges.
- R10: While running, a high pvdd_uv_i, gvdd_uv_i or gvdd_ov_i drives fault_n_o low and gate_kill_o high on the next clock edge.
- R11: fault_n_o stays low after the condition clears, and through a full shutdown. Only a quick-reset return or a fresh enable from off releases it.
- R12: temp_i is a two's-complement 9-bit Celsius value. Negative codes never set the warning or shutdown, for example -100 = 9'h19C.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Enable, synchronous to clk_i |
| oc_i | input | PHASES | Per-phase drain-source overcurrent flags |
| pvdd_uv_i | input | 1 | Supply undervoltage flag |
| gvdd_uv_i | input | 1 | Gate-supply undervoltage flag |
| gvdd_ov_i | input | 1 | Gate-supply overvoltage flag |
| temp_i | input | TEMP_W | Junction temperature, signed Celsius |
| fault_n_o | output | 1 | Latched shutdown fault, active low |
| warn_n_o | output | 1 | Overcurrent or over-temperature warning, active low |
| gate_kill_o | output | 1 | Forces all gate drives off |
| ready_o | output | 1 | Power stage released for switching |

## Verification
The hardest state to reach is a shutdown latch held by over-temperature whose hysteresis has not yet released. It is only visible at the ports as a fault line that drops again right after a quick reset. The bench reaches it by running past 150, easing back to 140 and pulsing enable for exactly QUICK_CYC cycles. It then repeats the pulse at 130 to confirm the release. The quick/full boundary is hit at QUICK_CYC and QUICK_CYC+1 low cycles. The temperature thresholds are swept over every signed code, up and then down, against an arithmetic hysteresis model.

// File: rtl/dfs_pkg.sv
package dfs_pkg;
  typedef enum logic [1:0] {
    ST_OFF   = 2'd0,
    ST_START = 2'd1,
    ST_RUN   = 2'd2,
    ST_HOLD  = 2'd3
  } seq_state_e;
endpackage

// File: rtl/dfs_enable_fsm.sv
module dfs_enable_fsm
  import dfs_pkg::*;
#(
  parameter int STARTUP_CYC = 375000,
  parameter int QUICK_CYC   = 500
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  output logic run_o,
  output logic clr_o
);
  localparam int MAXC  = (STARTUP_CYC > QUICK_CYC) ? STARTUP_CYC : QUICK_CYC;
  localparam int CNT_W = $clog2(MAXC + 1);
  localparam logic [CNT_W-1:0] START_LAST = CNT_W'(STARTUP_CYC - 1);
  localparam logic [CNT_W-1:0] QUICK_LAST = CNT_W'(QUICK_CYC - 1);

  seq_state_e state_q, state_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    unique case (state_q)
      ST_OFF: if (en_i) begin
        state_d = ST_START;
        cnt_d   = '0;
      end
      ST_START: begin
        if (!en_i)                    state_d = ST_OFF;
        else if (cnt_q == START_LAST) state_d = ST_RUN;
        else                          cnt_d   = cnt_q + 1'b1;
      end
      ST_RUN: if (!en_i) begin
        state_d = ST_HOLD;
        cnt_d   = '0;
      end
      ST_HOLD: begin
        // enable back inside the window: fast clear, no start-up wait
        if (en_i)                     state_d = ST_RUN;
        else if (cnt_q == QUICK_LAST) state_d = ST_OFF;
        else                          cnt_d   = cnt_q + 1'b1;
      end
      default: state_d = ST_OFF;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_OFF;
      cnt_q   <= '0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
    end
  end

  assign run_o = (state_q == ST_RUN);
  assign clr_o = en_i && ((state_q == ST_OFF) || (state_q == ST_HOLD));

  a_r2_start_waits: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_START && cnt_q != START_LAST) |=> (state_q != ST_RUN));
  a_r3_abort_start: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_START && !en_i) |=> (state_q == ST_OFF));
  a_r4_quick_return: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_HOLD && en_i) |=> (state_q == ST_RUN));
  a_r5_hold_bounded: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_HOLD) |-> (cnt_q <= QUICK_LAST));
  a_r6_low_stops_run: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!en_i) |=> (state_q != ST_RUN));
endmodule

// File: rtl/dfs_hyst_cmp.sv
module dfs_hyst_cmp #(
  parameter int TEMP_W = 9,
  parameter int SET_C  = 130,
  parameter int CLR_C  = 115
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic signed [TEMP_W-1:0] val_i,
  output logic                     flag_o
);
  localparam logic signed [TEMP_W-1:0] SET_T = TEMP_W'(SET_C);
  localparam logic signed [TEMP_W-1:0] CLR_T = TEMP_W'(CLR_C);

  logic flag_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              flag_q <= 1'b0;
    else if (val_i >= SET_T)  flag_q <= 1'b1;
    else if (val_i <= CLR_T)  flag_q <= 1'b0;
  end

  assign flag_o = flag_q;

  // shared by warning (R8) and shutdown (R9) instances
  a_r8_hold_in_band: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flag_q && val_i > CLR_T) |=> flag_q);
  a_r8_clear_in_band: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!flag_q && val_i < SET_T) |=> !flag_q);
  a_r12_negative_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!flag_q && val_i < 0) |=> !flag_q);
endmodule

// File: rtl/dfs_temp_hyst.sv
module dfs_temp_hyst #(
  parameter int TEMP_W   = 9,
  parameter int OTW_SET  = 130,
  parameter int OTW_CLR  = 115,
  parameter int OTSD_SET = 150,
  parameter int OTSD_CLR = 130
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [TEMP_W-1:0] temp_i,
  output logic              otw_o,
  output logic              otsd_o
);
  logic signed [TEMP_W-1:0] temp_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) temp_q <= '0;
    else         temp_q <= $signed(temp_i);
  end

  dfs_hyst_cmp #(.TEMP_W(TEMP_W), .SET_C(OTW_SET), .CLR_C(OTW_CLR)) u_warn (
    .clk_i(clk_i), .rst_ni(rst_ni), .val_i(temp_q), .flag_o(otw_o)
  );

  dfs_hyst_cmp #(.TEMP_W(TEMP_W), .SET_C(OTSD_SET), .CLR_C(OTSD_CLR)) u_shut (
    .clk_i(clk_i), .rst_ni(rst_ni), .val_i(temp_q), .flag_o(otsd_o)
  );
endmodule

// File: rtl/dfs_oc_stretch.sv
module dfs_oc_stretch #(
  parameter int STRETCH_CYC = 3200
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic oc_i,
  output logic active_o
);
  localparam int CNT_W = $clog2(STRETCH_CYC + 1);
  localparam logic [CNT_W-1:0] LOAD = CNT_W'(STRETCH_CYC);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          cnt_q <= '0;
    else if (oc_i)        cnt_q <= LOAD;
    else if (cnt_q != '0) cnt_q <= cnt_q - 1'b1;
  end

  assign active_o = (cnt_q != '0);

  a_r7_flag_reports: assert property (@(posedge clk_i) disable iff (!rst_ni)
    oc_i |=> active_o);
  a_r7_steady_countdown: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_q != '0 && !oc_i) |=> (cnt_q == $past(cnt_q) - 1'b1));
endmodule

// File: rtl/drv_fault_seq.sv
module drv_fault_seq #(
  parameter int PHASES         = 3,
  parameter int TEMP_W         = 9,
  parameter int STARTUP_CYC    = 375000,
  parameter int QUICK_CYC      = 500,
  parameter int OC_STRETCH_CYC = 3200,
  parameter int OTW_SET        = 130,
  parameter int OTW_CLR        = 115,
  parameter int OTSD_SET       = 150,
  parameter int OTSD_CLR       = 130
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic [PHASES-1:0] oc_i,
  input  logic              pvdd_uv_i,
  input  logic              gvdd_uv_i,
  input  logic              gvdd_ov_i,
  input  logic [TEMP_W-1:0] temp_i,
  output logic              fault_n_o,
  output logic              warn_n_o,
  output logic              gate_kill_o,
  output logic              ready_o
);
  logic run, clr, otw, otsd, sd_cond, fault_q;
  logic [PHASES-1:0] oc_act;

  dfs_enable_fsm #(.STARTUP_CYC(STARTUP_CYC), .QUICK_CYC(QUICK_CYC)) u_seq (
    .clk_i(clk_i), .rst_ni(rst_ni), .en_i(en_i), .run_o(run), .clr_o(clr)
  );

  dfs_temp_hyst #(
    .TEMP_W(TEMP_W), .OTW_SET(OTW_SET), .OTW_CLR(OTW_CLR),
    .OTSD_SET(OTSD_SET), .OTSD_CLR(OTSD_CLR)
  ) u_temp (
    .clk_i(clk_i), .rst_ni(rst_ni), .temp_i(temp_i), .otw_o(otw), .otsd_o(otsd)
  );

  for (genvar p = 0; p < PHASES; p++) begin : g_phase
    dfs_oc_stretch #(.STRETCH_CYC(OC_STRETCH_CYC)) u_oc (
      .clk_i(clk_i), .rst_ni(rst_ni), .oc_i(oc_i[p]), .active_o(oc_act[p])
    );
  end

  assign sd_cond = pvdd_uv_i | gvdd_uv_i | gvdd_ov_i | otsd;

  // latch sets only while running; released on quick return or fresh enable
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             fault_q <= 1'b0;
    else if (clr)            fault_q <= 1'b0;
    else if (run && sd_cond) fault_q <= 1'b1;
  end

  assign fault_n_o   = ~fault_q;
  assign gate_kill_o = ~run | fault_q;
  assign ready_o     = run;
  assign warn_n_o    = ~((|oc_act) | otw);

  a_r10_kill_with_fault: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !fault_n_o |-> gate_kill_o);
  a_r10_supply_trip: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ready_o && (pvdd_uv_i || gvdd_uv_i || gvdd_ov_i)) |=> !fault_n_o);
  a_r11_fault_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!fault_n_o && !en_i) |=> !fault_n_o);
  a_r7_oc_no_fault: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fault_n_o && !(ready_o && sd_cond)) |=> fault_n_o);
endmodule

// File: tb/drv_fault_seq_bench.sv
module drv_fault_seq_bench;
  localparam int S  = 40;
  localparam int Q  = 6;
  localparam int ST = 12;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic en = 1'b0;
  logic [2:0] oc = '0;
  logic [2:0] sup = '0;
  logic signed [8:0] temp = '0;
  logic fault_n, warn_n, kill, ready;

  int total = 0;
  int bad = 0;
  bit done = 0;

  always #10 clk = ~clk;

  drv_fault_seq #(
    .PHASES(3), .TEMP_W(9), .STARTUP_CYC(S), .QUICK_CYC(Q), .OC_STRETCH_CYC(ST)
  ) u_drv_fault_seq (
    .clk_i(clk), .rst_ni(rst_n), .en_i(en), .oc_i(oc),
    .pvdd_uv_i(sup[0]), .gvdd_uv_i(sup[1]), .gvdd_ov_i(sup[2]),
    .temp_i(temp), .fault_n_o(fault_n), .warn_n_o(warn_n),
    .gate_kill_o(kill), .ready_o(ready)
  );

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic quick_pulse();
    en = 1'b0;
    tick(1);
    check(ready == 1'b0, "R6 ready low in hold", int'(ready), 0);
    check(kill == 1'b1, "R6 kill high in hold", int'(kill), 1);
    tick(Q - 1);
    en = 1'b1;
    tick(1);
  endtask

  initial begin
    bit exp_otw;
    exp_otw = 1'b0;
    @(negedge clk);
    tick(2);
    rst_n = 1'b1;
    tick(1);
    check(ready == 1'b0, "R1 ready", int'(ready), 0);
    check(kill == 1'b1, "R1 kill", int'(kill), 1);
    check(fault_n == 1'b1, "R1 fault_n", int'(fault_n), 1);
    check(warn_n == 1'b1, "R1 warn_n", int'(warn_n), 1);

    // R8/R12 sweep of all signed codes, up then down, while off
    for (int t = -256; t <= 255; t++) begin
      temp = 9'(t);
      tick(2);
      if (t >= 130) exp_otw = 1'b1; else if (t <= 115) exp_otw = 1'b0;
      check(warn_n == !exp_otw, (t < 0) ? "R12 negative temp" : "R8 temp up",
            int'(warn_n), int'(!exp_otw));
    end
    for (int t = 255; t >= -256; t--) begin
      temp = 9'(t);
      tick(2);
      if (t >= 130) exp_otw = 1'b1; else if (t <= 115) exp_otw = 1'b0;
      check(warn_n == !exp_otw, (t < 0) ? "R12 negative temp" : "R8 temp down",
            int'(warn_n), int'(!exp_otw));
    end
    temp = 9'sd25;
    tick(2);

    // R7 stretch: every phase, held 1..3 cycles
    for (int p = 0; p < 3; p++) begin
      for (int h = 1; h <= 3; h++) begin
        oc[p] = 1'b1;
        for (int k = 1; k <= h + ST; k++) begin
          @(posedge clk);
          @(negedge clk);
          if (k == h) oc[p] = 1'b0;
          check(warn_n == (k >= h + ST), "R7 stretch width", int'(warn_n), int'(k >= h + ST));
        end
      end
    end

    // R3 abort during start-up, then R2 full wait
    en = 1'b1;
    tick(10);
    en = 1'b0;
    tick(2);
    check(ready == 1'b0, "R3 abort start", int'(ready), 0);
    en = 1'b1;
    for (int k = 1; k <= S + 1; k++) begin
      tick(1);
      check(ready == (k >= S + 1), "R2 start delay", int'(ready), int'(k >= S + 1));
      check(kill == (k < S + 1), "R2 kill release", int'(kill), int'(k < S + 1));
    end

    // R7 in run: warning only
    oc[1] = 1'b1;
    tick(1);
    oc[1] = 1'b0;
    check(warn_n == 1'b0, "R7 warn in run", int'(warn_n), 0);
    check(fault_n == 1'b1 && kill == 1'b0, "R7 oc no fault", int'(fault_n), 1);
    tick(ST + 1);

    // R10/R11/R4 per supply flag
    for (int i = 0; i < 3; i++) begin
      sup[i] = 1'b1;
      tick(1);
      check(fault_n == 1'b0, "R10 supply trip", int'(fault_n), 0);
      check(kill == 1'b1, "R10 kill", int'(kill), 1);
      sup[i] = 1'b0;
      tick(3);
      check(fault_n == 1'b0, "R11 fault held", int'(fault_n), 0);
      quick_pulse();
      check(ready == 1'b1, "R4 quick ready", int'(ready), 1);
      check(fault_n == 1'b1, "R4 quick clears", int'(fault_n), 1);
      tick(2);
      check(fault_n == 1'b1 && kill == 1'b0, "R4 stays clear", int'(fault_n), 1);
    end

    // R9 shutdown hysteresis via quick reset
    temp = 9'sd150;
    tick(3);
    check(fault_n == 1'b0, "R9 otsd trip", int'(fault_n), 0);
    check(kill == 1'b1, "R9 otsd kill", int'(kill), 1);
    temp = 9'sd140;
    tick(2);
    quick_pulse();
    check(fault_n == 1'b1, "R9 clear on return", int'(fault_n), 1);
    tick(1);
    check(fault_n == 1'b0, "R9 relatch above clear", int'(fault_n), 0);
    temp = 9'sd130;
    tick(3);
    quick_pulse();
    tick(3);
    check(fault_n == 1'b1, "R9 released at 130", int'(fault_n), 1);
    temp = 9'sd25;
    tick(3);

    // R5 full shutdown with a latched fault (R11)
    sup[0] = 1'b1;
    tick(1);
    sup[0] = 1'b0;
    en = 1'b0;
    tick(Q + 1);
    check(fault_n == 1'b0, "R11 held through shutdown", int'(fault_n), 0);
    en = 1'b1;
    tick(1);
    check(ready == 1'b0, "R5 full restart", int'(ready), 0);
    check(fault_n == 1'b1, "R11 cleared by enable", int'(fault_n), 1);
    tick(S - 1);
    check(ready == 1'b0, "R5 still waiting", int'(ready), 0);
    tick(1);
    check(ready == 1'b1, "R5 ready after wait", int'(ready), 1);

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule